// File: doc/BRIEF.md
# Write-Protected SPD Memory Controller

This block manages a 256-byte presence-detect store and sits behind a byte-level command port. Each request carries an operation code, an address and a data byte. Each request gets exactly one registered response on the following cycle. The response says whether the device acknowledged the request, and for reads it also returns a data byte. An internal address counter follows every access, so current-address reads and sequential bursts pick up where the last access left off.

The lower half of the store (00h–7Fh) can be locked against writes in two ways. A reversible lock can later be removed. A permanent lock cannot be removed. The upper half (80h–FFh) is always writable. Each write or protection command is followed by an internal write cycle of a fixed number of clocks. During that cycle the block refuses every request, so a host finds out when the cycle has ended by retrying until it gets an acknowledge. The bit-level serial layer and the nonvolatile cell are outside this block. Storage is a register array, and the write cycle is a counter.

Top module: `spd_store_ctrl`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low, the address counter is 00h and both protection locks are clear. Store contents are kept across reset.
- R2: A response (`rsp_valid` high) appears in the cycle after every request and in no other cycle.
- R3: An acknowledged byte write (op 1) stores its data at its address and sets the counter to the next address. `busy` then stays high for exactly BUSY_CYCLES cycles. While `busy` is high, every request gets `rsp_ack` low and changes nothing.
- R4: A selective read (op 5) returns the byte at its address and sets the counter to that address plus one.
- R5: A current-address read (op 4) returns the byte at the counter and advances the counter. After FFh the counter moves to 00h.
- R6: While a read burst is open, a host acknowledge (op 6) returns the next consecutive byte, wrapping from FFh to 00h. A stop (op 7) closes the burst. Op 6 outside a burst is refused.
- R7: A page write starts with op 2 (address and first byte). Each following op 3 stores one byte at the next address, and the address wraps inside its PAGE_BYTES-aligned page. The page write starts no write cycle until op 7 arrives, and op 7 does start one.
- R8: With any lock set, writes to 00h–7Fh are acknowledged but leave the store unchanged. Writes to 80h–FFh are still stored.
- R9: The unlock command (op 9) removes the reversible lock (set by op 8).
- R10: The permanent lock (op 10) cannot be removed. Op 9 is acknowledged but has no effect while the permanent lock is set.
- R11: Each lock and unlock command starts a write cycle of BUSY_CYCLES cycles, in the same way as a byte write.
- R12: Op codes 0 and 11–15 are refused and change neither the store nor the counter. Op 3 outside a page write is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see R3–R12) |
| req_addr | input | 8 | Byte address for write, page-start and selective-read requests |
| req_data | input | 8 | Write data byte |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_ack | output | 1 | Device acknowledged that request |
| rsp_data | output | 8 | Byte returned by an acknowledged read |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bound checker watches several rules on every cycle. It checks the one-to-one pairing of requests and responses, and that requests made while busy are refused. It also checks that no store write ever lands in the locked half, that the permanent lock never drops, that the busy counter stays inside its bound, and that every current-address read steps the counter by one. Other behaviour needs a history of stimulus, so only the directed scenarios can show it. That covers the exact length of the write cycle, stored values read back after wrap-around, page roll-over inside a page, an unlock that is ignored under the permanent lock, and contents that survive a reset.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_BYTE_WR   = 4'd1,
    OP_PAGE_WR   = 4'd2,
    OP_PAGE_DATA = 4'd3,
    OP_CUR_RD    = 4'd4,
    OP_SEL_RD    = 4'd5,
    OP_RD_ACK    = 4'd6,
    OP_STOP      = 4'd7,
    OP_LOCK_REV  = 4'd8,
    OP_UNLOCK    = 4'd9,
    OP_LOCK_PERM = 4'd10
  } spd_op_e;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PAGE = 2'd1,
    MODE_READ = 2'd2
  } spd_mode_e;
endpackage

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
  parameter int BUSY_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic [$clog2(BUSY_CYCLES+1)-1:0] count
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy  = (cnt_q != '0);
  assign count = cnt_q;
endmodule

// File: rtl/spd_protect.sv
module spd_protect #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_rev,
  input  logic              clr_rev,
  input  logic              set_perm,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              locked,
  output logic              rev_q,
  output logic              perm_q
);
  logic rev_d, perm_d, rev_en, perm_en;

  always_comb begin
    rev_en  = set_rev | (clr_rev & ~perm_q);
    rev_d   = set_rev;
    perm_en = set_perm;
    perm_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q  <= 1'b0;
      perm_q <= 1'b0;
    end else begin
      if (rev_en)  rev_q  <= rev_d;
      if (perm_en) perm_q <= perm_d;
    end
  end

  assign locked = ~chk_addr[ADDR_W-1] & (rev_q | perm_q);
endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spd_store_ctrl.sv
module spd_store_ctrl
  import spd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  spd_mode_e         mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rsp_valid_q, rsp_ack_q, rsp_ack_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic              data_en;

  logic              accept, want_wr, mem_we, locked;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic              start_busy, set_rev, clr_rev, set_perm;
  logic              prot_rev, prot_perm;
  logic [CW-1:0]     busy_count;
  spd_op_e           op;

  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] inc;
    inc = a + 1'b1;
    return (a & ~PAGE_MASK) | (inc & PAGE_MASK);
  endfunction

  spd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_busy),
    .busy  (busy),
    .count (busy_count)
  );

  spd_protect #(.ADDR_W(ADDR_W)) u_protect (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_rev  (set_rev),
    .clr_rev  (clr_rev),
    .set_perm (set_perm),
    .chk_addr (mem_waddr),
    .locked   (locked),
    .rev_q    (prot_rev),
    .perm_q   (prot_perm)
  );

  spd_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (req_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  assign op     = spd_op_e'(req_op);
  assign accept = req_valid & ~busy;
  assign mem_we = want_wr & ~locked;

  always_comb begin
    mode_d     = mode_q;
    addr_d     = addr_q;
    rsp_ack_d  = 1'b0;
    rsp_data_d = rsp_data_q;
    data_en    = 1'b0;
    want_wr    = 1'b0;
    mem_waddr  = addr_q;
    mem_raddr  = addr_q;
    start_busy = 1'b0;
    set_rev    = 1'b0;
    clr_rev    = 1'b0;
    set_perm   = 1'b0;
    if (accept) begin
      unique case (op)
        OP_BYTE_WR: if (mode_q != MODE_PAGE) begin
          rsp_ack_d  = 1'b1;
          want_wr    = 1'b1;
          mem_waddr  = req_addr;
          addr_d     = req_addr + 1'b1;
          start_busy = 1'b1;
          mode_d     = MODE_IDLE;
        end
        OP_PAGE_WR: if (mode_q != MODE_PAGE) begin
          rsp_ack_d = 1'b1;
          want_wr   = 1'b1;
          mem_waddr = req_addr;
          addr_d    = page_step(req_addr);
          mode_d    = MODE_PAGE;
        end
        OP_PAGE_DATA: if (mode_q == MODE_PAGE) begin
          rsp_ack_d = 1'b1;
          want_wr   = 1'b1;
          addr_d    = page_step(addr_q);
        end
        OP_CUR_RD, OP_SEL_RD: if (mode_q != MODE_PAGE) begin
          rsp_ack_d  = 1'b1;
          mem_raddr  = (op == OP_SEL_RD) ? req_addr : addr_q;
          rsp_data_d = mem_rdata;
          data_en    = 1'b1;
          addr_d     = mem_raddr + 1'b1;
          mode_d     = MODE_READ;
        end
        OP_RD_ACK: if (mode_q == MODE_READ) begin
          rsp_ack_d  = 1'b1;
          rsp_data_d = mem_rdata;
          data_en    = 1'b1;
          addr_d     = addr_q + 1'b1;
        end
        OP_STOP: begin
          rsp_ack_d  = 1'b1;
          start_busy = (mode_q == MODE_PAGE);
          mode_d     = MODE_IDLE;
        end
        OP_LOCK_REV, OP_UNLOCK, OP_LOCK_PERM: if (mode_q != MODE_PAGE) begin
          rsp_ack_d  = 1'b1;
          set_rev    = (op == OP_LOCK_REV);
          clr_rev    = (op == OP_UNLOCK);
          set_perm   = (op == OP_LOCK_PERM);
          start_busy = 1'b1;
          mode_d     = MODE_IDLE;
        end
        default: rsp_ack_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_IDLE;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_ack_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      mode_q      <= mode_d;
      addr_q      <= addr_d;
      rsp_valid_q <= req_valid;
      rsp_ack_q   <= rsp_ack_d;
      if (data_en) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ack   = rsp_ack_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/spd_store_ctrl_chk.sv
module spd_store_ctrl_chk #(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 1250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_ack,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              prot_rev,
  input logic              prot_perm,
  input logic [ADDR_W-1:0] addr_q,
  input logic [$clog2(BUSY_CYCLES+1)-1:0] busy_count
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r3_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !rsp_ack);
  a_r3_busy_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rsp_ack);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_count <= ($clog2(BUSY_CYCLES+1))'(BUSY_CYCLES));
  a_r8_locked_half: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_waddr[ADDR_W-1]) |-> !(prot_rev || prot_perm));
  a_r10_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot_perm |=> prot_perm);
  a_r5_cur_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 4'd4) |=> (!rsp_ack || addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

bind spd_store_ctrl spd_store_ctrl_chk #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .rsp_valid  (rsp_valid),
  .rsp_ack    (rsp_ack),
  .busy       (busy),
  .mem_we     (mem_we),
  .mem_waddr  (mem_waddr),
  .prot_rev   (prot_rev),
  .prot_perm  (prot_perm),
  .addr_q     (addr_q),
  .busy_count (busy_count)
);

// File: tb/spd_store_ctrl_bench.sv
`timescale 1ns/1ps
module spd_store_ctrl_bench;
  localparam int NB = 12;
  localparam int PB = 16;

  logic       clk, rst_n, req_valid;
  logic [3:0] req_op;
  logic [7:0] req_addr, req_data;
  logic       rsp_valid, rsp_ack, busy;
  logic [7:0] rsp_data;

  int  n_checks, n_fail;
  bit  done;
  logic [7:0] mdl [256];
  logic [7:0] m_cnt;
  bit  m_lock;

  spd_store_ctrl #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(PB), .BUSY_CYCLES(NB)) u_spd_store_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] d,
                       output logic ack, output logic [7:0] q);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    ack = rsp_ack; q = rsp_data;
    check(rsp_valid === 1'b1, "R2 response after request", rsp_valid, 1);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit chk_len);
    logic ack; logic [7:0] q; int n;
    issue(4'd1, a, d, ack, q);
    check(ack === 1'b1, "R3 byte write acked", ack, 1);
    if (!(m_lock && !a[7])) mdl[a] = d;
    m_cnt = a + 8'd1;
    wait_idle(n);
    if (chk_len) check(n == NB, "R3 write cycle length", n, NB);
  endtask

  task automatic expect_rd(input logic [3:0] op, input logic [7:0] a, input string tag);
    logic ack; logic [7:0] q; logic [7:0] at;
    at = (op == 4'd5) ? a : m_cnt;
    issue(op, a, 8'h00, ack, q);
    check(ack === 1'b1 && q === mdl[at], tag, {ack, q}, {1'b1, mdl[at]});
    m_cnt = at + 8'd1;
  endtask

  task automatic t_reset;
    int n;
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && rsp_valid === 1'b0, "R1 idle outputs in reset", {busy, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2 no response without request", rsp_valid, 0);
    wait_idle(n);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 256; i++) wr(8'(i), 8'(i) ^ 8'hA5, (i == 3));
  endtask

  task automatic t_reset_keeps;
    wr(8'h00, 8'h5A, 1'b0);
    wr(8'h40, 8'h3C, 1'b0);
    t_reset;
    m_cnt = 8'h00;
    m_lock = 1'b0;
    expect_rd(4'd4, 8'h00, "R1 counter zero and contents kept");
  endtask

  task automatic t_busy_refuse;
    logic ack; logic [7:0] q; int n;
    issue(4'd1, 8'h90, 8'h11, ack, q);
    mdl[8'h90] = 8'h11; m_cnt = 8'h91;
    issue(4'd1, 8'h90, 8'hEE, ack, q);
    check(ack === 1'b0, "R3 write refused while busy", ack, 0);
    issue(4'd5, 8'h10, 8'h00, ack, q);
    check(ack === 1'b0, "R3 read refused while busy", ack, 0);
    wait_idle(n);
    expect_rd(4'd5, 8'h90, "R3 refused write left byte");
    expect_rd(4'd4, 8'h00, "R3 counter untouched by refused read");
  endtask

  task automatic t_reads;
    wr(8'hFE, 8'h71, 1'b0); wr(8'hFF, 8'h72, 1'b0); wr(8'h00, 8'h73, 1'b0);
    expect_rd(4'd5, 8'h37, "R4 selective read");
    expect_rd(4'd4, 8'h00, "R4 counter after selective read");
    expect_rd(4'd5, 8'hFE, "R5 selective read FEh");
    expect_rd(4'd4, 8'h00, "R5 current read FFh");
    expect_rd(4'd4, 8'h00, "R5 current read wraps to 00h");
  endtask

  task automatic t_seq;
    logic ack; logic [7:0] q;
    expect_rd(4'd5, 8'hFD, "R6 burst start");
    expect_rd(4'd6, 8'h00, "R6 burst next FEh");
    expect_rd(4'd6, 8'h00, "R6 burst next FFh");
    expect_rd(4'd6, 8'h00, "R6 burst wraps to 00h");
    issue(4'd7, 8'h00, 8'h00, ack, q);
    check(busy === 1'b0, "R6 stop after read starts no write cycle", busy, 0);
    issue(4'd6, 8'h00, 8'h00, ack, q);
    check(ack === 1'b0, "R6 host ack outside burst refused", ack, 0);
  endtask

  task automatic t_page;
    logic ack; logic [7:0] q; int n;
    logic [7:0] a;
    a = 8'hBC;
    issue(4'd2, a, 8'hC0, ack, q);
    check(ack === 1'b1 && busy === 1'b0, "R7 page start acked, no cycle", {ack, busy}, 2);
    mdl[a] = 8'hC0;
    for (int k = 1; k < 6; k++) begin
      a = (a & 8'hF0) | ((a + 8'd1) & 8'h0F);
      issue(4'd3, 8'h00, 8'hC0 + 8'(k), ack, q);
      check(ack === 1'b1, "R7 page data acked", ack, 1);
      mdl[a] = 8'hC0 + 8'(k);
    end
    m_cnt = (a & 8'hF0) | ((a + 8'd1) & 8'h0F);
    check(busy === 1'b0, "R7 no write cycle before stop", busy, 0);
    issue(4'd7, 8'h00, 8'h00, ack, q);
    wait_idle(n);
    check(n == NB, "R7 stop starts write cycle", n, NB);
    expect_rd(4'd5, 8'hB0, "R7 roll-over landed at B0h");
    expect_rd(4'd5, 8'hBF, "R7 byte at BFh");
    expect_rd(4'd5, 8'hC0, "R7 next page untouched");
    issue(4'd3, 8'h00, 8'h55, ack, q);
    check(ack === 1'b0, "R12 page data outside page refused", ack, 0);
  endtask

  task automatic t_bad_op;
    logic ack; logic [7:0] q;
    m_cnt = 8'h31;
    expect_rd(4'd5, 8'h30, "R12 setup read");
    issue(4'hF, 8'h30, 8'h00, ack, q);
    check(ack === 1'b0, "R12 op 15 refused", ack, 0);
    issue(4'h0, 8'h30, 8'h00, ack, q);
    check(ack === 1'b0, "R12 op 0 refused", ack, 0);
    expect_rd(4'd4, 8'h00, "R12 counter unchanged by bad op");
  endtask

  task automatic lock_cmd(input logic [3:0] op, input string tag);
    logic ack; logic [7:0] q; int n;
    issue(op, 8'h00, 8'h00, ack, q);
    check(ack === 1'b1, tag, ack, 1);
    wait_idle(n);
    check(n == NB, "R11 lock command write cycle", n, NB);
  endtask

  task automatic t_protect;
    lock_cmd(4'd8, "R8 reversible lock acked");
    m_lock = 1'b1;
    wr(8'h20, 8'h99, 1'b0);
    expect_rd(4'd5, 8'h20, "R8 locked byte unchanged");
    wr(8'hA0, 8'h98, 1'b0);
    expect_rd(4'd5, 8'hA0, "R8 upper half still writable");
    wr(8'h7F, 8'h97, 1'b0);
    expect_rd(4'd5, 8'h7F, "R8 7Fh locked");
    lock_cmd(4'd9, "R9 unlock acked");
    m_lock = 1'b0;
    wr(8'h20, 8'h96, 1'b0);
    expect_rd(4'd5, 8'h20, "R9 write stored after unlock");
    lock_cmd(4'd10, "R10 permanent lock acked");
    m_lock = 1'b1;
    lock_cmd(4'd9, "R10 unlock acked under permanent lock");
    wr(8'h21, 8'h95, 1'b0);
    expect_rd(4'd5, 8'h21, "R10 unlock had no effect");
    wr(8'hFF, 8'h94, 1'b0);
    expect_rd(4'd5, 8'hFF, "R10 upper half writable");
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    m_cnt = 8'h00; m_lock = 1'b0;
    t_reset;
    t_fill;
    t_reset_keeps;
    t_busy_refuse;
    t_reads;
    t_seq;
    t_page;
    t_bad_op;
    t_protect;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule